// File: doc/BRIEF.md
# Sixteen-Bit Interval Timer With Control Byte

The block is a down-counting interval timer. A sixteen-bit reload value is written a byte at a time into a holding latch. An eight-bit control byte sets how the counter runs. The counter advances on every system clock, or on each rising edge of an external count input. When it passes zero it reloads from the latch and sends a one-cycle underflow pulse to a separate interrupt block.

The timer runs either continuously or once. In once mode it stops by clearing its own run bit. A strobe bit in the control byte forces an immediate reload and is never stored. The timer can also drive a port pin, either as a one-clock pulse per underflow or as a level that flips on each underflow. When it does not drive the pin, the pin follows a plain port value. The two top control bits are kept and read back but control nothing in this block.

Register map. Writes go to address 0 (latch low byte), address 1 (latch high byte) and address 2 (control byte). Reads return the live counter low byte at address 0, the counter high byte at address 1, the control byte at address 2, and zero at address 3. Control bits: bit 0 run, bit 1 drive pin, bit 2 flip style, bit 3 once, bit 4 reload strobe, bit 5 external source, bits 7:6 spare.

Top module: `pit_timer`

## Requirements
- R1: After reset the counter and latch hold 0xFFFF, the control byte reads 0x00, `uflow` is low and `port_out` equals `port_in`.
- R2: With bit 0 = 1 and bit 5 = 0 the counter drops by one each clock. A tick that finds the counter at 0 reloads it from the latch, so a continuous run underflows every latch+1 clocks. With bit 0 = 0 the counter holds its value.
- R3: Each underflow raises `uflow` for one clock, in the cycle after the tick that found the counter at 0. No other event raises `uflow`.
- R4: With bit 3 = 1 (once) the underflow reloads the counter and clears bit 0, and no further underflow follows. With bit 3 = 0 the run continues.
- R5: Writing bit 4 = 1 in the control byte copies the latch into the counter on that write, taking precedence over a tick. Bit 4 always reads back as 0.
- R6: A write to address 0 or 1 changes only the latch, except that a write to address 1 while bit 0 = 0 also loads the whole new latch value into the counter. Addresses 0 and 1 read the live counter.
- R7: Bits 7:6 are stored and read back, and do not start, stop or change the counter.
- R8: With bit 5 = 1 the counter drops by one for each rising edge of `cnt_in` and ignores the system clock. A held-high level counts once.
- R9: With bit 1 = 0, `port_out` equals `port_in`. With bit 1 = 1 it shows the timer output.
- R10: With bits 1 = 1 and 2 = 0, `port_out` is high for exactly the one clock in which `uflow` is high.
- R11: With bits 1 = 1 and 2 = 1, `port_out` is set high by the write that starts the timer and inverts on each underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| cnt_in | input | 1 | External count input, asynchronous |
| port_in | input | 1 | Plain port value used when the timer does not drive the pin |
| uflow | output | 1 | One-clock underflow pulse to the interrupt block |
| port_out | output | 1 | Port pin value |

## Verification
A register write takes effect at the clock edge that samples it, and its result is read on the next half cycle. After a start that lands at edge w, the first underflow shows on `uflow` at edge w+latch+1, and later ones follow every latch+1 edges. The pulse-style pin output appears in the same cycle as `uflow`. An external edge reaches the counter two synchroniser stages plus one edge-detect register later, so those checks wait a margin of several clocks. The bench counts edges since reset and pushes the edge number of each expected underflow into a queue. A monitor pops and compares the queue on every falling edge where `uflow` is high, and all pin checks are timed by the same edge count.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_LO   = 2'd0;
    localparam logic [ADDR_W-1:0] A_HI   = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;

    typedef struct packed {
        logic [1:0] spare;   // bits 7:6, stored only
        logic       ext_src; // bit 5
        logic       reload;  // bit 4, strobe, never stored
        logic       once;    // bit 3
        logic       flip;    // bit 2
        logic       drive;   // bit 1
        logic       run;     // bit 0
    } ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] latch;
        ctrl_t            ctrl;
    } core_st_t;
endpackage

// File: rtl/pit_edge_sync.sv
module pit_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sync_q, sync_d;
    logic              prev_q;

    if (STAGES > 1) begin : g_chain
        always_comb sync_d = {sync_q[STAGES-2:0], din};
    end else begin : g_single
        always_comb sync_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;

    // R8: one edge yields one count enable
    p_one_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/pit_core.sv
module pit_core
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ext_rise,
    output logic [CNT_W-1:0]  count,
    output ctrl_t             ctrl,
    output logic              uf,
    output logic              start_rise
);
    core_st_t st_q, st_d;
    ctrl_t    wr_ctrl;
    logic     tick;

    always_comb begin
        st_d       = st_q;
        uf         = 1'b0;
        start_rise = 1'b0;
        wr_ctrl    = ctrl_t'(wdata);
        tick       = st_q.ctrl.run && (st_q.ctrl.ext_src ? ext_rise : 1'b1);

        if (tick) begin
            if (st_q.count == '0) begin
                uf         = 1'b1;
                st_d.count = st_q.latch;
                if (st_q.ctrl.once) st_d.ctrl.run = 1'b0;
            end else begin
                st_d.count = st_q.count - CNT_W'(1);
            end
        end

        if (wr_en) begin
            unique case (addr)
                A_LO: st_d.latch[BYTE_W-1:0] = wdata;
                A_HI: begin
                    st_d.latch[CNT_W-1:BYTE_W] = wdata;
                    if (!st_q.ctrl.run) st_d.count = {wdata, st_q.latch[BYTE_W-1:0]};
                end
                A_CTRL: begin
                    st_d.ctrl        = wr_ctrl;
                    st_d.ctrl.reload = 1'b0;
                    start_rise       = wr_ctrl.run && !st_q.ctrl.run;
                    if (wr_ctrl.reload) st_d.count = st_q.latch;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.count <= '1;
            st_q.latch <= '1;
            st_q.ctrl  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.count;
    assign ctrl  = st_q.ctrl;

    // R2: underflow leaves the latch value in the counter
    p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> (st_q.count == $past(st_q.latch)));

    // R2: a stopped counter without writes holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.run && !wr_en) |=> $stable(st_q.count));

    // R4: once mode stops itself
    p_once_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && st_q.ctrl.once && !(wr_en && addr == A_CTRL)) |=> !st_q.ctrl.run);

    // R5: the strobe is never stored
    p_no_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl.reload);
endmodule

// File: rtl/pit_out_stage.sv
module pit_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic drive,
    input  logic flip_mode,
    input  logic uf,
    input  logic start_rise,
    input  logic port_in,
    output logic uflow,
    output logic port_out
);
    typedef struct packed {
        logic pulse;
        logic level;
    } out_st_t;

    out_st_t st_q, st_d;

    always_comb begin
        st_d.pulse = uf;
        st_d.level = st_q.level;
        if (start_rise)  st_d.level = 1'b1;
        else if (uf)     st_d.level = ~st_q.level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign uflow    = st_q.pulse;
    assign port_out = drive ? (flip_mode ? st_q.level : st_q.pulse) : port_in;

    // R11: each underflow inverts the level
    p_flip_r11: assert property (@(posedge clk) disable iff (!rst_n)
        uf |=> (st_q.level != $past(st_q.level)));
endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              cnt_in,
    input  logic              port_in,
    output logic              uflow,
    output logic              port_out
);
    logic             ext_rise;
    logic [CNT_W-1:0] count;
    ctrl_t            ctrl;
    logic             uf;
    logic             start_rise;

    pit_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cnt_in),
        .rise (ext_rise)
    );

    pit_core core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .ext_rise  (ext_rise),
        .count     (count),
        .ctrl      (ctrl),
        .uf        (uf),
        .start_rise(start_rise)
    );

    pit_out_stage out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .drive     (ctrl.drive),
        .flip_mode (ctrl.flip),
        .uf        (uf),
        .start_rise(start_rise),
        .port_in   (port_in),
        .uflow     (uflow),
        .port_out  (port_out)
    );

    always_comb begin
        unique case (addr)
            A_LO:    rdata = count[BYTE_W-1:0];
            A_HI:    rdata = count[CNT_W-1:BYTE_W];
            A_CTRL:  rdata = BYTE_W'(ctrl);
            default: rdata = '0;
        endcase
    end

    // R5: strobe bit reads zero at the port
    p_strobe_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_CTRL) |-> !rdata[4]);
endmodule

// File: tb/pit_timer_tb_top.sv
module pit_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       cnt_in;
    logic       port_in;
    logic       uflow;
    logic       port_out;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    int exp_q[$];

    pit_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cnt_in(cnt_in), .port_in(port_in), .uflow(uflow),
        .port_out(port_out)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, output int w);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        w = cyc;
    endtask

    task automatic rd16(output int v);
        logic [7:0] lo;
        addr = 2'd0; #1; lo = rdata;
        addr = 2'd1; #1; v = {rdata, lo};
    endtask

    task automatic rd8(input logic [1:0] a, output int v);
        addr = a; #1; v = rdata;
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // scoreboard monitor: each underflow pulse pops one expected edge number
    always @(negedge clk) begin
        if (rst_n && uflow) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R3: unexpected uflow act=%0d exp=none", cyc);
            end else begin
                chk("R3", "uflow cycle", cyc, exp_q.pop_front());
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 5000) begin
            errors++; checks++;
            $display("FAIL watchdog: act=%0d exp<=5000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int w, v;
        rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
        cnt_in = 1'b0; port_in = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd16(v);          chk("R1", "count after reset", v, 16'hFFFF);
        rd8(2'd2, v);     chk("R1", "ctrl after reset", v, 8'h00);
        chk("R1", "uflow after reset", uflow, 0);
        chk("R1", "port_out after reset", port_out, 1);

        // R7 spare bits stored, no effect
        wr(2'd2, 8'hC0, w);
        rd8(2'd2, v);     chk("R7", "spare readback", v, 8'hC0);
        repeat (5) @(negedge clk);
        rd16(v);          chk("R7", "count unaffected", v, 16'hFFFF);

        // R6 high write while stopped loads counter
        wr(2'd0, 8'h03, w);
        rd16(v);          chk("R6", "low write alone", v, 16'hFFFF);
        wr(2'd1, 8'h00, w);
        rd16(v);          chk("R6", "stopped high write loads", v, 16'h0003);

        // R2/R3 continuous, latch 3
        wr(2'd2, 8'h01, w);
        exp_q.push_back(w + 4); exp_q.push_back(w + 8); exp_q.push_back(w + 12);
        wait_to(w + 1);
        rd16(v);          chk("R2", "decrement per clock", v, 2);
        wait_to(w + 12);
        wr(2'd2, 8'h00, v);
        repeat (4) @(negedge clk);
        rd16(v);          chk("R2", "stopped holds", v, 1);

        // R6/R5 running: high write does not load, strobe does
        wr(2'd0, 8'h00, w);
        wr(2'd1, 8'h01, w);
        wr(2'd2, 8'h01, w);
        wr(2'd1, 8'h05, v);
        rd16(v);          chk("R6", "running high write no load", v, 16'h00FE);
        wr(2'd2, 8'h11, v);
        rd16(v);          chk("R5", "strobe loads over tick", v, 16'h0500);
        rd8(2'd2, v);     chk("R5", "strobe reads zero", v, 8'h01);
        wr(2'd2, 8'h00, v);

        // R8 external edges
        wr(2'd0, 8'h10, w);
        wr(2'd1, 8'h00, w);
        wr(2'd2, 8'h21, w);
        repeat (8) @(negedge clk);
        rd16(v);          chk("R8", "clock ignored", v, 16'h0010);
        for (int i = 0; i < 3; i++) begin
            cnt_in = 1'b1; repeat (3) @(negedge clk);
            cnt_in = 1'b0; repeat (3) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        rd16(v);          chk("R8", "three edges", v, 16'h000D);
        cnt_in = 1'b1; repeat (10) @(negedge clk);
        rd16(v);          chk("R8", "held high counts once", v, 16'h000C);
        cnt_in = 1'b0;
        wr(2'd2, 8'h00, w);

        // R10/R4 pulse output, once mode, latch 2
        port_in = 1'b0;
        wr(2'd0, 8'h02, w);
        wr(2'd1, 8'h00, w);
        wr(2'd2, 8'h0B, w);
        exp_q.push_back(w + 3);
        wait_to(w + 2);   chk("R10", "pin before underflow", port_out, 0);
        wait_to(w + 3);   chk("R10", "pin on underflow", port_out, 1);
        wait_to(w + 4);   chk("R10", "pin after underflow", port_out, 0);
        rd8(2'd2, v);     chk("R4", "run cleared in once mode", v, 8'h0A);
        rd16(v);          chk("R4", "reloaded after once", v, 2);
        wait_to(w + 12);
        rd16(v);          chk("R4", "no further run", v, 2);

        // R11/R9 flip output, continuous, latch 1, port_in high
        port_in = 1'b1;
        wr(2'd0, 8'h01, w);
        wr(2'd1, 8'h00, w);
        wr(2'd2, 8'h07, w);
        exp_q.push_back(w + 2); exp_q.push_back(w + 4);
        exp_q.push_back(w + 6); exp_q.push_back(w + 8);
        chk("R11", "start sets level", port_out, 1);
        wait_to(w + 1);   chk("R11", "level w+1", port_out, 1);
        wait_to(w + 2);   chk("R9", "timer drives pin, not port_in", port_out, 0);
        wait_to(w + 3);   chk("R11", "level w+3", port_out, 0);
        wait_to(w + 4);   chk("R11", "level w+4", port_out, 1);
        wait_to(w + 5);   chk("R11", "level w+5", port_out, 1);
        wait_to(w + 6);   chk("R11", "level w+6", port_out, 0);
        wr(2'd2, 8'h00, v);

        // R9 pin released
        port_in = 1'b0; @(negedge clk);
        chk("R9", "pin follows port_in low", port_out, 0);
        port_in = 1'b1; #1;
        chk("R9", "pin follows port_in high", port_out, 1);

        repeat (6) @(negedge clk);
        chk("R3", "all expected pulses seen", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule